// File: doc/BRIEF.md
# Key Matrix Encoder with Lamp Decoder

This block reads a local panel of 32 pushbuttons wired as 8 rows by 4 columns and turns each accepted button press into a 5-bit binary key number. It drives the rows low one at a time, reads the column lines, and filters each key against contact bounce. A key is reported only after it has read as pressed over a programmable number of consecutive scans. When several keys are held at once, every key that becomes newly pressed is reported, so the latest one wins. Releasing a key never produces a report.

The block also feeds a second 8-by-4 matrix of indicator lamps. It does the reverse of the key encoding and lights exactly one lamp at the position of the selected 5-bit number. Normally that number is the last key reported. An external code can override it, for example a selection that arrives over a serial link. The lamp outputs are statically decoded: one row is driven high and one column is driven low.

Top module: `keymat_panel`

## Requirements
- R1: `row_drv_n` always has exactly one bit low. The low bit starts at row 0 after reset, stays on each row for SETTLE_CYC clock cycles, and then steps to the next row in ascending order, wrapping from the last row to row 0.
- R2: A pressed key pulls its column line low while its row is driven. The key at row r and column c is reported as code r*COLS + c, which is r*4 + c with the default sizes.
- R3: A key is reported only after DEB_SCANS consecutive samples of its row read it as pressed. With one scan being ROWS*SETTLE_CYC cycles, the report comes between (DEB_SCANS-1) and DEB_SCANS scans after the press. A press shorter than that is never reported.
- R4: `key_valid` is a one-cycle pulse with each report. `key_code` carries the reported code from that cycle on and holds it until the next report.
- R5: A key that becomes newly pressed while another key is still held is reported with its own code.
- R6: Releasing any key, alone or while others stay held, produces no pulse on `key_valid` and leaves `key_code` unchanged.
- R7: When keys in the same row finish debouncing on the same sample, only the lowest code among them is reported. The others are taken as held and are not reported.
- R8: While a selection is live, `led_row` has one bit high at index code/COLS and `led_col_n` has one bit low at index code%COLS. All other lamp lines stay inactive.
- R9: While `ext_sel_en` is 1, the lamps show `ext_code` instead of the last reported key. When `ext_sel_en` returns to 0, the lamps show the last reported key again.
- R10: After reset, `key_valid` is 0 and the lamps are dark (`led_row` all 0, `led_col_n` all 1). They stay dark until the first key report, unless `ext_sel_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_n | input | COLS | Column return lines, low where a key in the driven row is pressed |
| ext_sel_en | input | 1 | Makes the lamps show ext_code |
| ext_code | input | CODE_W | External lamp selection |
| row_drv_n | output | ROWS | Row drive, one line low at a time |
| key_code | output | CODE_W | Last reported key number |
| key_valid | output | 1 | One-cycle strobe for a new report |
| led_row | output | ROWS | Lamp row drive, active high |
| led_col_n | output | COLS | Lamp column drive, active low |

## Verification
A debounce counter or stable state that is wrong in a single key appears at the ports within DEB_SCANS+1 scans. It shows up as a missing report, an early report, or a spurious report when that key is released. A fault in the row stepping corrupts `row_drv_n` within one SETTLE_CYC dwell, and it also sends codes to the wrong row. A fault in the tie selection or in the lamp decode shows up in the very cycle of the report, either in the value of `key_code` or in the lamp lines that are lit.

// File: rtl/keymat_pkg.sv
package keymat_pkg;
  function automatic int code_of(input int row, input int col, input int cols);
    return row * cols + col;
  endfunction

  function automatic int row_of(input int code, input int cols);
    return code / cols;
  endfunction

  function automatic int col_of(input int code, input int cols);
    return code % cols;
  endfunction
endpackage

// File: rtl/keymat_scan.sv
module keymat_scan #(
  parameter int ROWS = 8,
  parameter int SETTLE_CYC = 64,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int DW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [ROWS-1:0] row_drv_n,
  output logic [RW-1:0]   row_idx,
  output logic            sample_now
);
  logic [DW-1:0] dwell;

  assign sample_now = (dwell == DW'(SETTLE_CYC - 1));
  assign row_drv_n  = ~(ROWS'(1) << row_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell   <= '0;
      row_idx <= '0;
    end else if (sample_now) begin
      dwell   <= '0;
      row_idx <= (row_idx == RW'(ROWS - 1)) ? '0 : row_idx + 1'b1;
    end else begin
      dwell <= dwell + 1'b1;
    end
  end

  a_r1_single_row: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_drv_n) == 1);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |=> row_drv_n != $past(row_drv_n));
  a_r1_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_now |=> $stable(row_drv_n));
endmodule

// File: rtl/keymat_debounce.sv
module keymat_debounce
  import keymat_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 4,
  parameter int DEB_SCANS = 4,
  localparam int KEYS = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NW = (DEB_SCANS > 1) ? $clog2(DEB_SCANS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_now,
  input  logic [RW-1:0]   row_idx,
  input  logic [COLS-1:0] col_n,
  output logic [KEYS-1:0] press_evt
);
  for (genvar k = 0; k < KEYS; k++) begin : g_key
    localparam int KR = row_of(k, COLS);
    localparam int KC = col_of(k, COLS);
    logic          mine, raw, held, done;
    logic [NW-1:0] run;

    assign mine = sample_now && (row_idx == RW'(KR));
    assign raw  = ~col_n[KC];
    assign done = (run == NW'(DEB_SCANS - 1));
    assign press_evt[k] = mine && raw && !held && done;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held <= 1'b0;
        run  <= '0;
      end else if (mine) begin
        if (raw == held) begin
          run <= '0;
        end else if (done) begin
          held <= raw;
          run  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  end

  a_r3_evt_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (|press_evt) |-> sample_now);
endmodule

// File: rtl/keymat_pick.sv
module keymat_pick #(
  parameter int KEYS = 32,
  localparam int CW = (KEYS > 1) ? $clog2(KEYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] press_evt,
  output logic [CW-1:0]   key_code,
  output logic            key_valid,
  output logic            have_code
);
  logic [CW-1:0] winner;
  logic          any_evt;

  assign any_evt = |press_evt;

  always_comb begin
    winner = '0;
    for (int k = KEYS - 1; k >= 0; k--) begin
      if (press_evt[k]) winner = CW'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_code  <= '0;
      key_valid <= 1'b0;
      have_code <= 1'b0;
    end else begin
      key_valid <= any_evt;
      if (any_evt) begin
        key_code  <= winner;
        have_code <= 1'b1;
      end
    end
  end

  a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(key_code));
  a_r10_live_after_report: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> have_code);
endmodule

// File: rtl/keymat_lamp.sv
module keymat_lamp
  import keymat_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 4,
  localparam int KEYS = ROWS * COLS,
  localparam int CW = (KEYS > 1) ? $clog2(KEYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            have_code,
  input  logic [CW-1:0]   key_code,
  input  logic            ext_sel_en,
  input  logic [CW-1:0]   ext_code,
  output logic [ROWS-1:0] led_row,
  output logic [COLS-1:0] led_col_n
);
  logic [CW-1:0] sel;
  logic          lit;
  int            sel_i;

  assign sel   = ext_sel_en ? ext_code : key_code;
  assign sel_i = int'(sel);
  assign lit   = (ext_sel_en || have_code) && (sel_i < KEYS);

  always_comb begin
    led_row   = '0;
    led_col_n = '1;
    if (lit) begin
      led_row[row_of(sel_i, COLS)]   = 1'b1;
      led_col_n[col_of(sel_i, COLS)] = 1'b0;
    end
  end

  a_r8_one_lamp: assert property (@(posedge clk) disable iff (!rst_n)
    lit |-> ($countones(led_row) == 1 && $countones(~led_col_n) == 1));
  a_r10_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel_en && !have_code) |-> (led_row == '0 && led_col_n == '1));
endmodule

// File: rtl/keymat_panel.sv
module keymat_panel #(
  parameter int ROWS = 8,
  parameter int COLS = 4,
  parameter int SETTLE_CYC = 64,
  parameter int DEB_SCANS = 4,
  localparam int KEYS = ROWS * COLS,
  localparam int CODE_W = (KEYS > 1) ? $clog2(KEYS) : 1,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COLS-1:0]   col_n,
  input  logic              ext_sel_en,
  input  logic [CODE_W-1:0] ext_code,
  output logic [ROWS-1:0]   row_drv_n,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid,
  output logic [ROWS-1:0]   led_row,
  output logic [COLS-1:0]   led_col_n
);
  logic [RW-1:0]   row_idx;
  logic            sample_now;
  logic [KEYS-1:0] press_evt;
  logic            have_code;

  keymat_scan #(.ROWS(ROWS), .SETTLE_CYC(SETTLE_CYC)) u_scan (
    .clk(clk), .rst_n(rst_n), .row_drv_n(row_drv_n),
    .row_idx(row_idx), .sample_now(sample_now));

  keymat_debounce #(.ROWS(ROWS), .COLS(COLS), .DEB_SCANS(DEB_SCANS)) u_deb (
    .clk(clk), .rst_n(rst_n), .sample_now(sample_now), .row_idx(row_idx),
    .col_n(col_n), .press_evt(press_evt));

  keymat_pick #(.KEYS(KEYS)) u_pick (
    .clk(clk), .rst_n(rst_n), .press_evt(press_evt), .key_code(key_code),
    .key_valid(key_valid), .have_code(have_code));

  keymat_lamp #(.ROWS(ROWS), .COLS(COLS)) u_lamp (
    .clk(clk), .rst_n(rst_n), .have_code(have_code), .key_code(key_code),
    .ext_sel_en(ext_sel_en), .ext_code(ext_code),
    .led_row(led_row), .led_col_n(led_col_n));

  a_r2_report_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> $past(sample_now));
endmodule

// File: tb/test_keymat_panel.sv
module test_keymat_panel;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int COLS = 4;
  localparam int SETTLE = 4;
  localparam int DEB = 3;
  localparam int SCAN = ROWS * SETTLE;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [COLS-1:0] col_n;
  logic            ext_sel_en = 1'b0;
  logic [4:0]      ext_code = '0;
  logic [ROWS-1:0] row_drv_n;
  logic [4:0]      key_code;
  logic            key_valid;
  logic [ROWS-1:0] led_row;
  logic [COLS-1:0] led_col_n;
  logic [31:0]     press_map = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keymat_panel #(.ROWS(ROWS), .COLS(COLS), .SETTLE_CYC(SETTLE), .DEB_SCANS(DEB)) i_keymat_panel (
    .clk(clk), .rst_n(rst_n), .col_n(col_n), .ext_sel_en(ext_sel_en),
    .ext_code(ext_code), .row_drv_n(row_drv_n), .key_code(key_code),
    .key_valid(key_valid), .led_row(led_row), .led_col_n(led_col_n));

  // Panel model: a pressed key shorts its column to the driven row.
  always_comb begin
    col_n = '1;
    for (int k = 0; k < 32; k++) begin
      if (press_map[k] && !row_drv_n[k / COLS]) col_n[k % COLS] = 1'b0;
    end
  end

  function automatic logic [ROWS-1:0] exp_led_row(input int code);
    return ROWS'(1) << (code / COLS);
  endfunction

  function automatic logic [COLS-1:0] exp_led_col(input int code);
    return ~(COLS'(1) << (code % COLS));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_report(input int exp, input string tag, output int lat);
    int got = -1;
    lat = -1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (key_valid) begin
        got = int'(key_code);
        lat = i + 1;
        break;
      end
    end
    check(got == exp, tag, got, exp);
  endtask

  task automatic expect_quiet(input int cycles, input string tag);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (key_valid) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  task automatic check_led(input int code, input string tag);
    check(led_row == exp_led_row(code), {tag, " led_row"}, int'(led_row), int'(exp_led_row(code)));
    check(led_col_n == exp_led_col(code), {tag, " led_col_n"}, int'(led_col_n), int'(exp_led_col(code)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int bad;
    int prev;
    int run;
    bit moved;
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check(row_drv_n == 8'hFE, "R10 row0 after reset", int'(row_drv_n), 254);
    check(key_valid == 1'b0, "R10 no strobe", int'(key_valid), 0);
    check(led_row == '0 && led_col_n == '1, "R10 lamps dark", int'(led_row), 0);

    // R1: scan order and dwell
    bad = 0; prev = -1; run = 0; moved = 0;
    for (int i = 0; i < 3 * SCAN; i++) begin
      int idx = -1;
      if ($countones(~row_drv_n) != 1) bad++;
      for (int r = 0; r < ROWS; r++) if (!row_drv_n[r]) idx = r;
      if (prev >= 0 && idx != prev) begin
        if (idx != (prev + 1) % ROWS) bad++;
        if (moved && run != SETTLE) bad++;
        moved = 1; run = 1;
      end else run++;
      prev = idx;
      @(negedge clk);
    end
    check(bad == 0, "R1 row scan", bad, 0);

    // R9: external override lights lamps before any key
    ext_sel_en = 1'b1; ext_code = 5'd19;
    @(negedge clk);
    check_led(19, "R9 ext before key");
    ext_sel_en = 1'b0;
    @(negedge clk);
    check(led_row == '0, "R10 dark again", int'(led_row), 0);

    // R3: short press is filtered
    press_map[13] = 1'b1;
    repeat (40) @(negedge clk);
    press_map[13] = 1'b0;
    expect_quiet(200, "R3 bounce ignored");

    // R2 R3: single press, code and latency
    press_map[6] = 1'b1;
    expect_report(6, "R2 code of row1 col2", lat);
    check(lat >= (DEB - 1) * SCAN && lat <= DEB * SCAN + 2, "R3 latency", lat, DEB * SCAN);
    check_led(6, "R8 lamp for 6");
    repeat (5) @(negedge clk);
    check(key_valid == 1'b0, "R4 pulse ended", int'(key_valid), 0);
    check(key_code == 5'd6, "R4 code held", int'(key_code), 6);

    // R5: rollover
    press_map[27] = 1'b1;
    expect_report(27, "R5 rollover new key", lat);
    // R6: releases are silent
    press_map[27] = 1'b0;
    expect_quiet(200, "R6 release while other held");
    press_map[6] = 1'b0;
    expect_quiet(200, "R6 release last key");
    check(key_code == 5'd27, "R6 code unchanged", int'(key_code), 27);
    check_led(27, "R8 lamp holds");

    // R7: same-row tie, lowest code wins
    press_map[9] = 1'b1; press_map[10] = 1'b1;
    expect_report(9, "R7 lowest in row", lat);
    expect_quiet(200, "R7 other key silent");
    press_map[9] = 1'b0; press_map[10] = 1'b0;
    expect_quiet(200, "R6 tie release");

    // Random single presses and external selections
    for (int n = 0; n < 16; n++) begin
      int k = int'($urandom % 32);
      int e = int'($urandom % 32);
      press_map[k] = 1'b1;
      expect_report(k, "R2 random key", lat);
      check_led(k, "R8 random lamp");
      ext_sel_en = 1'b1; ext_code = 5'(e);
      @(negedge clk);
      check_led(e, "R9 random ext");
      ext_sel_en = 1'b0;
      @(negedge clk);
      check_led(k, "R9 back to key");
      press_map[k] = 1'b0;
      expect_quiet(150, "R6 random release");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule